// File: doc/BRIEF.md
# Rate-Divided Galois Pseudonoise Chip Generator

This block produces a continuous pseudonoise chip stream from a right-shifting Galois linear feedback shift register. The register does not advance on every clock: it advances once for every `DIV_N` pulses of an external one-cycle sample strobe. The chip rate is therefore a fixed fraction of the sample rate. Each advance emits exactly one chip, and the stream keeps running for as many sequence periods as the system needs.

The register length, the feedback polynomial, the seed and the divide factor are parameters. The polynomial is given with one bit set per tap exponent, leaving out the constant term. The block shifts that value right by one to form the XOR mask. With the defaults (16 stages, taps at 16, 14, 13 and 11, seed 3, divide by 10) the sequence is maximal length and repeats every 65,535 chips. The chip is presented on its own pin, as a one-clock valid pulse, and on bit 0 of a 4-bit digital output word.

Top module: `pn_chip_gen`

## Requirements
- R1: While `rst_ni` is low, and on the first sampling after it is released, `chip_o`, `chip_vld_o` and `dig_out_o` are all 0, the divide counter is 0 and the register holds the seed.
- R2: The divide counter counts sample strobes from 0 to `DIV_N`-1. The strobe seen when it equals `DIV_N`-1 advances the register and wraps the counter to 0. `chip_vld_o` is high for exactly the one clock after that strobe's edge and is low after every other edge.
- R3: A clock with `sample_stb_i` low changes neither the counter nor the register, and raises no `chip_vld_o`.
- R4: On each advance the register LSB is captured into `chip_o`. The register then becomes its value shifted right by one, XORed with the feedback mask when the captured LSB was 1.
- R5: The feedback mask is the polynomial parameter shifted right by one and truncated to `LEN` bits. For the defaults this is 16'hB400, so from seed 3 the first three chips are 1, 1, 0.
- R6: `chip_o` holds its value between advances.
- R7: `dig_out_o` carries `chip_o` on bit 0, and bits 3 to 1 are always 0.
- R8: With maximal-length taps the register never holds zero and the chip sequence repeats with period 2^`LEN`-1. For `LEN`=4, polynomial 5'h18 and seed 1, the chips over one period are 1,0,0,1,1,0,1,0,1,1,1,1,0,0,0.
- R9: With `DIV_N`=1, every sample strobe advances the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_stb_i | input | 1 | One-cycle sample strobe |
| chip_o | output | 1 | Current pseudonoise chip |
| chip_vld_o | output | 1 | One-clock pulse on each new chip |
| dig_out_o | output | 4 | Digital output word, chip on bit 0 |

## Verification
The assertions assume that `sample_stb_i` is a clean synchronous level that is sampled once per clock. They make no assumption about spacing, so the strobe may be high on consecutive clocks or absent for long stretches. The bench drives the strobe at the falling clock edge with a random density. It then adds a long idle gap, an unbroken run of strobes and a reset in the middle of the run. This keeps every input inside those assumptions while covering back-to-back advances and long hold periods.

// File: rtl/pn_pkg.sv
package pn_pkg;
  localparam int unsigned MAX_LEN = 32;

  // One right-shifting Galois step on a zero-extended register.
  function automatic logic [MAX_LEN-1:0] galois_step(input logic [MAX_LEN-1:0] s,
                                                     input logic [MAX_LEN-1:0] m);
    return (s >> 1) ^ (s[0] ? m : '0);
  endfunction
endpackage

// File: rtl/pn_rate_div.sv
module pn_rate_div #(
  parameter int unsigned DIV_N = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = stb_i && (cnt_q == LAST);

  generate
    if (DIV_N > 1) begin : g_count
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else if (stb_i)  cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_pass
      assign cnt_q = '0;
    end
  endgenerate
endmodule

// File: rtl/pn_galois_lfsr.sv
module pn_galois_lfsr
  import pn_pkg::*;
#(
  parameter int unsigned     LEN  = 16,
  parameter logic [LEN-1:0]  MASK = 16'hB400,
  parameter logic [LEN-1:0]  SEED = 16'd3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  output logic [LEN-1:0] state_o
);
  logic [LEN-1:0]     state_q;
  logic [MAX_LEN-1:0] next_w;

  assign next_w  = galois_step(MAX_LEN'(state_q), MAX_LEN'(MASK));
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= next_w[LEN-1:0];
  end
endmodule

// File: rtl/pn_chip_gen.sv
module pn_chip_gen #(
  parameter int unsigned  LEN   = 16,
  parameter logic [32:0]  POLY  = 33'h0_0001_6800,
  parameter logic [31:0]  SEED  = 32'd3,
  parameter int unsigned  DIV_N = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sample_stb_i,
  output logic       chip_o,
  output logic       chip_vld_o,
  output logic [3:0] dig_out_o
);
  localparam logic [32:0]    POLY_SH = POLY >> 1;
  localparam logic [LEN-1:0] MASK    = POLY_SH[LEN-1:0];
  localparam logic [LEN-1:0] SEED_L  = SEED[LEN-1:0];

  initial begin
    if (LEN < 2 || LEN > 32) $error("pn_chip_gen: LEN out of range");
    if (SEED_L == '0)        $error("pn_chip_gen: zero seed");
    if (DIV_N < 1)           $error("pn_chip_gen: DIV_N below 1");
  end

  logic           tick_w;
  logic [LEN-1:0] state_w;
  logic           chip_q, vld_q;

  pn_rate_div #(.DIV_N(DIV_N)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (sample_stb_i),
    .tick_o(tick_w)
  );

  pn_galois_lfsr #(.LEN(LEN), .MASK(MASK), .SEED(SEED_L)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (tick_w),
    .state_o(state_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= tick_w;
      if (tick_w) chip_q <= state_w[0];
    end
  end

  assign chip_o     = chip_q;
  assign chip_vld_o = vld_q;
  assign dig_out_o  = {3'b000, chip_q};
endmodule

// File: rtl/pn_chip_gen_chk.sv
module pn_chip_gen_chk #(
  parameter int unsigned    LEN   = 16,
  parameter logic [LEN-1:0] MASK  = 16'hB400,
  parameter int unsigned    DIV_N = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sample_stb_i,
  input logic           chip_o,
  input logic           chip_vld_o,
  input logic [3:0]     dig_out_o,
  input logic [LEN-1:0] state_i
);
  logic [31:0] stb_cnt_q;
  logic        last_w;

  assign last_w = sample_stb_i && (stb_cnt_q == 32'(DIV_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            stb_cnt_q <= '0;
    else if (last_w)        stb_cnt_q <= '0;
    else if (sample_stb_i)  stb_cnt_q <= stb_cnt_q + 1;
  end

  assert_advance_on_nth_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_w |=> chip_vld_o);
  assert_no_early_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_w |=> !chip_vld_o);
  assert_idle_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_stb_i |=> $stable(state_i));
  assert_galois_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_w |=> (chip_o == $past(state_i[0])) &&
               (state_i == (($past(state_i) >> 1) ^ ($past(state_i[0]) ? MASK : '0))));
  assert_chip_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_w |=> $stable(chip_o));
  assert_dout_map_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_out_o == {3'b000, chip_o});
  assert_state_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != '0);
endmodule

bind pn_chip_gen pn_chip_gen_chk #(.LEN(LEN), .MASK(MASK), .DIV_N(DIV_N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_stb_i(sample_stb_i),
  .chip_o      (chip_o),
  .chip_vld_o  (chip_vld_o),
  .dig_out_o   (dig_out_o),
  .state_i     (state_w)
);

// File: tb/tb_pn_chip_gen.sv
`timescale 1ns/1ps
module tb_pn_chip_gen;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stb = 1'b0;
  logic chip, vld, s_chip, s_vld;
  logic [3:0] dout, s_dout;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pn_chip_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_stb_i(stb),
    .chip_o(chip), .chip_vld_o(vld), .dig_out_o(dout)
  );

  pn_chip_gen #(.LEN(4), .POLY(33'h18), .SEED(32'd1), .DIV_N(1)) dut_small (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_stb_i(stb),
    .chip_o(s_chip), .chip_vld_o(s_vld), .dig_out_o(s_dout)
  );

  // Behavioural reference for the default instance
  int   m_cnt;
  logic [31:0] m_reg;
  logic m_chip, m_vld;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_reg = 32'd3; m_chip = 1'b0; m_vld = 1'b0;
    end else begin
      m_vld = 1'b0;
      if (stb) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 10) begin
          m_cnt  = 0;
          m_chip = m_reg[0];
          m_reg  = m_reg[0] ? ((m_reg >> 1) ^ 32'h0000_B400) : (m_reg >> 1);
          m_vld  = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int first_chips[3];
  int n_first = 0;
  int small_chips[64];
  int n_small = 0;
  bit track_small = 0;

  task automatic compare_cycle();
    chk(stb ? "R2 valid" : "R3 valid while idle", vld, m_vld);
    chk(m_vld ? "R4 chip" : "R6 chip hold", chip, m_chip);
    chk("R7 dig_out", dout, {3'b000, m_chip});
    if (vld && n_first < 3) begin first_chips[n_first] = chip; n_first++; end
    if (track_small && s_vld && n_small < 64) begin small_chips[n_small] = s_chip; n_small++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 chip in reset", chip, 0);
    chk("R1 valid in reset", vld, 0);
    chk("R1 dig_out in reset", dout, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 chip after release", chip, 0);
    chk("R1 valid after release", vld, 0);

    // random strobe density
    for (int i = 0; i < 3000; i++) begin
      stb = ($urandom_range(0, 99) < 55);
      @(negedge clk_i);
      compare_cycle();
    end
    chk("R5 first chip", first_chips[0], 1);
    chk("R5 second chip", first_chips[1], 1);
    chk("R5 third chip", first_chips[2], 0);

    // long idle gap
    stb = 1'b0;
    for (int i = 0; i < 60; i++) begin @(negedge clk_i); compare_cycle(); end

    // mid-run reset, then continuous strobes
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 chip mid reset", chip, 0);
    chk("R1 valid mid reset", vld, 0);
    chk("R1 small chip mid reset", s_chip, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_cycle();
    stb = 1'b1;
    track_small = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      compare_cycle();
      chk("R9 small valid every strobe", s_vld, 1);
    end
    stb = 1'b0;
    @(negedge clk_i);
    compare_cycle();
    track_small = 0;

    begin
      int exp_seq[15] = '{1,0,0,1,1,0,1,0,1,1,1,1,0,0,0};
      int ones = 0;
      chk("R8 small chip count", (n_small >= 45) ? 1 : 0, 1);
      for (int i = 0; i < 15; i++) begin
        chk("R8 small sequence", small_chips[i], exp_seq[i]);
        ones += small_chips[i];
      end
      for (int i = 0; i < 30; i++) chk("R8 period 15", small_chips[i + 15], small_chips[i]);
      chk("R8 ones per period", ones, 8);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule